// File: doc/BRIEF.md
# Dual Synchronizable Interval Timer

This block keeps two 16-bit up-counters that step together on one shared count-enable tick. Each counter has its own period value. The primary counter has two ways to return to zero. In the first, it wraps when its count matches the primary period. In the second, it is cleared by one of up to 31 external sync lines, chosen by a 5-bit selector. Each time it returns to zero it raises an interrupt pulse and a sync pulse that other timers can follow. The primary counter also drives an A/D trigger pulse when its count reaches a compare value.

The secondary counter is a plain periodic interrupt source. It has no sync input, no sync output and no trigger.

Software writes a period of zero to park a counter. A parked counter stays at zero and raises no interrupts. Period changes act on the very next comparison, because the period values are not double-buffered. While the module enable is low, both counters are held at zero.

Top module: `twin_timebase`

## Requirements
- R1: While `run` is low, or while `rst` is high, both counts read 0 and every pulse output stays low.
- R2: With `run` high, each `tick` cycle adds one to each non-parked counter. A cycle without `tick` (and, for the primary, without a selected sync) leaves both counts unchanged.
- R3: With `sync_sel` = 0 and `per_pri` non-zero, a tick that finds `cnt_pri` equal to `per_pri` returns it to 0. `pri_irq` and `sync_out` are then high for exactly the one cycle in which `cnt_pri` first reads 0, so one interval spans `per_pri`+1 ticks.
- R4: With `sync_sel` = k (1..31), a high level on `sync_in[k-1]` in any cycle while `run` is high clears `cnt_pri` and raises one `pri_irq`/`sync_out` pulse. In this mode `per_pri` has no effect, and the other sync lines have no effect.
- R5: With `sync_sel` non-zero and no sync arriving, `cnt_pri` counts through 16'hFFFF to 0, with one `pri_irq`/`sync_out` pulse at that rollover.
- R6: The secondary counter returns to 0 on a tick that finds `cnt_sec` equal to a non-zero `per_sec`, and raises `sec_irq` for the cycle in which it reads 0. `sync_sel` and `sync_in` never alter it.
- R7: A zero `per_sec` holds `cnt_sec` at 0 with `sec_irq` low. A zero `per_pri` does the same for the primary counter while `sync_sel` = 0.
- R8: A period change is applied at the very next tick comparison, with no buffering.
- R9: `adc_trig` is high for one cycle when the primary counter has just been updated (by a tick or a sync) to a value equal to `adc_cmp`. That cycle is the first cycle in which `cnt_pri` shows that value.
- R10: A selected sync that arrives in the same cycle as a tick wins. The count goes to 0 rather than being incremented, and only one pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Module enable; low holds both counters at 0 |
| tick | input | 1 | Shared count-enable |
| sync_sel | input | 5 | 0 = period wrap; k = follow `sync_in[k-1]` |
| sync_in | input | 31 | External sync lines |
| per_pri | input | 16 | Primary period |
| per_sec | input | 16 | Secondary period |
| adc_cmp | input | 16 | A/D trigger compare value |
| cnt_pri | output | 16 | Primary count |
| cnt_sec | output | 16 | Secondary count |
| pri_irq | output | 1 | Primary interrupt pulse |
| sec_irq | output | 1 | Secondary interrupt pulse |
| sync_out | output | 1 | Sync pulse on primary return to 0 |
| adc_trig | output | 1 | A/D trigger pulse |

## Verification
Assertions check the following on every cycle:
- the enable hold and the zero-period hold
- the period-match wrap and the sync clear of the primary counter
- single steps on a tick, and a stable count without one
- that an interrupt only coincides with a zero count
- that a trigger matches the compare value held one cycle earlier

Only the bench scenarios can show the other behaviours:
- which sync line a given selector value picks, and that the others are ignored
- that a mid-count period change is used at once
- that the 16-bit rollover in sync mode raises a pulse
- that the secondary counter is unaffected by sync activity

// File: rtl/twin_tmr_pkg.sv
`timescale 1ns/1ps
package twin_tmr_pkg;
  localparam int unsigned DEF_CNT_W = 16;
  localparam int unsigned DEF_SEL_W = 5;

  // Reason a lane returned to zero on the current edge
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_MATCH = 2'd1,
    EV_ROLL  = 2'd2,
    EV_SYNC  = 2'd3
  } wrap_cause_e;
endpackage

// File: rtl/tmr_sync_pick.sv
`timescale 1ns/1ps
module tmr_sync_pick #(
  parameter int unsigned SEL_W = twin_tmr_pkg::DEF_SEL_W
) (
  input  logic [SEL_W-1:0]        sel,
  input  logic [(2**SEL_W)-2:0]   sync_in,
  output logic                    ext_mode,
  output logic                    hit
);
  localparam int unsigned NSYNC = (2**SEL_W) - 1;

  always_comb begin
    ext_mode = (sel != '0);
    hit      = 1'b0;
    for (int i = 1; i <= NSYNC; i++) begin
      if (sel == SEL_W'(i)) hit = sync_in[i-1];
    end
  end
endmodule

// File: rtl/tmr_lane.sv
`timescale 1ns/1ps
module tmr_lane import twin_tmr_pkg::*; #(
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter bit          HAS_EXT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             ext_mode,
  input  logic             ext_hit,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             upd,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] TOP_VAL = '1;

  logic ext, hit, hold, at_top, at_per;
  wrap_cause_e cause;

  generate
    if (HAS_EXT) begin : g_ext
      assign ext = ext_mode;
      assign hit = ext_mode & ext_hit;
    end else begin : g_noext
      logic unused_ext;
      assign unused_ext = ext_mode ^ ext_hit;
      assign ext = 1'b0;
      assign hit = 1'b0;
    end
  endgenerate

  always_comb begin
    hold    = !run || (!ext && (period == '0));
    at_top  = (cnt == TOP_VAL);
    at_per  = !ext && (cnt == period);
    cnt_nxt = cnt;
    upd     = 1'b0;
    cause   = EV_NONE;
    if (hold) begin
      cnt_nxt = '0;
    end else if (hit) begin
      cnt_nxt = '0;
      upd     = 1'b1;
      cause   = EV_SYNC;
    end else if (tick) begin
      upd = 1'b1;
      if (at_per) begin
        cnt_nxt = '0;
        cause   = EV_MATCH;
      end else if (at_top) begin
        cnt_nxt = '0;
        cause   = EV_ROLL;
      end else begin
        cnt_nxt = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      wrap <= 1'b0;
    end else begin
      cnt  <= cnt_nxt;
      wrap <= (cause != EV_NONE);
    end
  end

  // R1: disabled lane reads zero with no pulse
  assert_run_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0) && !wrap);

  // R7: zero period parks the lane
  assert_zero_park_R7: assert property (@(posedge clk) disable iff (rst)
    (!ext && period == '0) |=> (cnt == '0) && !wrap);

  // R3: period match returns to zero with a pulse
  assert_match_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (run && !ext && period != '0 && !hit && tick && cnt == period)
      |=> (cnt == '0) && wrap);

  // R4: selected sync clears the count with a pulse
  assert_sync_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (run && hit) |=> (cnt == '0) && wrap);

  // R2: single step on a plain tick
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!hold && !hit && tick && !at_top && !at_per)
      |=> cnt == $past(cnt) + 1'b1);

  // R2: no tick, no change
  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!hold && !hit && !tick) |=> $stable(cnt));

  // R3: a pulse is only seen with a zero count
  assert_pulse_zero_R3: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (cnt == '0));
endmodule

// File: rtl/tmr_adc_cmp.sv
`timescale 1ns/1ps
module tmr_adc_cmp #(
  parameter int unsigned CNT_W = twin_tmr_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] cmp,
  output logic             trig
);
  always_ff @(posedge clk) begin
    if (rst) trig <= 1'b0;
    else     trig <= upd && (cnt_nxt == cmp);
  end
endmodule

// File: rtl/twin_timebase.sv
`timescale 1ns/1ps
module twin_timebase import twin_tmr_pkg::*; #(
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned SEL_W = DEF_SEL_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic                  tick,
  input  logic [SEL_W-1:0]      sync_sel,
  input  logic [(2**SEL_W)-2:0] sync_in,
  input  logic [CNT_W-1:0]      per_pri,
  input  logic [CNT_W-1:0]      per_sec,
  input  logic [CNT_W-1:0]      adc_cmp,
  output logic [CNT_W-1:0]      cnt_pri,
  output logic [CNT_W-1:0]      cnt_sec,
  output logic                  pri_irq,
  output logic                  sec_irq,
  output logic                  sync_out,
  output logic                  adc_trig
);
  logic             ext_mode, ext_hit;
  logic [CNT_W-1:0] pri_nxt, sec_nxt;
  logic             pri_upd, sec_upd, pri_wrap, sec_wrap;

  tmr_sync_pick #(.SEL_W(SEL_W)) u_pick (
    .sel      (sync_sel),
    .sync_in  (sync_in),
    .ext_mode (ext_mode),
    .hit      (ext_hit)
  );

  tmr_lane #(.CNT_W(CNT_W), .HAS_EXT(1'b1)) u_pri (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .tick     (tick),
    .ext_mode (ext_mode),
    .ext_hit  (ext_hit),
    .period   (per_pri),
    .cnt      (cnt_pri),
    .cnt_nxt  (pri_nxt),
    .upd      (pri_upd),
    .wrap     (pri_wrap)
  );

  tmr_lane #(.CNT_W(CNT_W), .HAS_EXT(1'b0)) u_sec (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .tick     (tick),
    .ext_mode (1'b0),
    .ext_hit  (1'b0),
    .period   (per_sec),
    .cnt      (cnt_sec),
    .cnt_nxt  (sec_nxt),
    .upd      (sec_upd),
    .wrap     (sec_wrap)
  );

  tmr_adc_cmp #(.CNT_W(CNT_W)) u_adc (
    .clk     (clk),
    .rst     (rst),
    .upd     (pri_upd),
    .cnt_nxt (pri_nxt),
    .cmp     (adc_cmp),
    .trig    (adc_trig)
  );

  assign pri_irq  = pri_wrap;
  assign sync_out = pri_wrap;
  assign sec_irq  = sec_wrap;

  // R9: trigger only where the shown count equals last cycle's compare value
  assert_trig_match_R9: assert property (@(posedge clk) disable iff (rst)
    adc_trig |-> (cnt_pri == $past(adc_cmp)));

  // R6: secondary pulse coincides with a zero count
  assert_sec_zero_R6: assert property (@(posedge clk) disable iff (rst)
    sec_irq |-> (cnt_sec == '0));

  // R6: secondary only moves on a tick, never on a sync
  assert_sec_tick_only_R6: assert property (@(posedge clk) disable iff (rst)
    sec_upd |-> tick);

  // R6: secondary next value stays within its period once inside it
  assert_sec_range_R6: assert property (@(posedge clk) disable iff (rst)
    (sec_upd && per_sec != '0 && cnt_sec <= per_sec) |-> (sec_nxt <= per_sec));
endmodule

// File: tb/sim_twin_timebase.sv
`timescale 1ns/1ps
module sim_twin_timebase;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        tick = 1'b0;
  logic [4:0]  sync_sel = '0;
  logic [30:0] sync_in = '0;
  logic [15:0] per_pri = '0, per_sec = '0, adc_cmp = '0;
  logic [15:0] cnt_pri, cnt_sec;
  logic        pri_irq, sec_irq, sync_out, adc_trig;

  always #5 clk = ~clk;

  twin_timebase u0 (
    .clk(clk), .rst(rst), .run(run), .tick(tick),
    .sync_sel(sync_sel), .sync_in(sync_in),
    .per_pri(per_pri), .per_sec(per_sec), .adc_cmp(adc_cmp),
    .cnt_pri(cnt_pri), .cnt_sec(cnt_sec),
    .pri_irq(pri_irq), .sec_irq(sec_irq),
    .sync_out(sync_out), .adc_trig(adc_trig)
  );

  typedef struct {
    logic [15:0] cp, cs;
    logic        pi, si, so, at;
    string       req;
  } exp_t;

  exp_t  q[$];
  int    total = 0, bad = 0;
  string cur_req = "R1";

  // next-cycle configuration, applied by the driver
  logic        b_rst = 1'b1, b_run = 1'b0;
  logic [4:0]  b_sel = '0;
  logic [15:0] b_pp = '0, b_ps = '0, b_cmp = '0;
  logic [15:0] mp = '0, ms = '0;

  task automatic step(input logic tk, input logic [30:0] sv);
    exp_t        e;
    logic        ext, hit, hp, hs, up, ep, es;
    logic [15:0] np, ns;
    @(negedge clk);
    rst = b_rst; run = b_run; sync_sel = b_sel;
    per_pri = b_pp; per_sec = b_ps; adc_cmp = b_cmp;
    tick = tk; sync_in = sv;
    ext = (b_sel != 5'd0);
    hit = 1'b0;
    if (ext) hit = sv[b_sel - 5'd1];
    hp = b_rst || !b_run || (!ext && b_pp == 16'd0);
    hs = b_rst || !b_run || (b_ps == 16'd0);
    np = mp; up = 1'b0; ep = 1'b0;
    if (hp) np = 16'd0;
    else if (hit) begin np = 16'd0; up = 1'b1; ep = 1'b1; end
    else if (tk) begin
      up = 1'b1;
      if ((!ext && mp == b_pp) || mp == 16'hFFFF) begin np = 16'd0; ep = 1'b1; end
      else np = mp + 16'd1;
    end
    ns = ms; es = 1'b0;
    if (hs) ns = 16'd0;
    else if (tk) begin
      if (ms == b_ps || ms == 16'hFFFF) begin ns = 16'd0; es = 1'b1; end
      else ns = ms + 16'd1;
    end
    e.cp = np; e.cs = ns; e.pi = ep; e.so = ep; e.si = es;
    e.at = up && (np == b_cmp);
    e.req = cur_req;
    q.push_back(e);
    mp = np; ms = ns;
  endtask

  task automatic chk(input string f, input int act, input int exp_v, input string req);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, f, act, exp_v, $time);
    end
  endtask

  // monitor: pops expected items as results appear
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk("cnt_pri",  int'(cnt_pri),  int'(e.cp), e.req);
        chk("cnt_sec",  int'(cnt_sec),  int'(e.cs), e.req);
        chk("pri_irq",  int'(pri_irq),  int'(e.pi), e.req);
        chk("sec_irq",  int'(sec_irq),  int'(e.si), e.req);
        chk("sync_out", int'(sync_out), int'(e.so), e.req);
        chk("adc_trig", int'(adc_trig), int'(e.at), e.req);
      end
    end
  end

  initial begin
    #1_900_000;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    for (int i = 0; i < 3; i++) step(1'b1, '0);
    b_rst = 1'b0; b_pp = 16'd4; b_ps = 16'd6; b_cmp = 16'd2;
    // R1: enable low holds everything
    for (int i = 0; i < 5; i++) step(1'b1, 31'h7FFF_FFFF);

    // R3 / R6 / R9: period wrap, secondary wrap, trigger
    b_run = 1'b1;
    cur_req = "R3";
    for (int i = 0; i < 16; i++) step(1'b1, '0);
    // R2: cycles without tick keep counts
    cur_req = "R2";
    for (int i = 0; i < 4; i++) step(i[0], '0);
    // R4: sync lines ignored while selector is zero; R6 secondary untouched
    cur_req = "R4";
    for (int i = 0; i < 6; i++) step(1'b1, 31'h0000_00FF);

    // R8: unbuffered period change mid-count
    cur_req = "R8";
    b_pp = 16'd10;
    while (mp != 16'd5) step(1'b1, '0);
    b_pp = 16'd7;
    for (int i = 0; i < 12; i++) step(1'b1, '0);

    // R7: zero periods park both counters
    cur_req = "R7";
    b_pp = 16'd0; b_ps = 16'd0;
    for (int i = 0; i < 5; i++) step(1'b1, '0);
    b_ps = 16'd3;

    // R4: sync line 3 selected, period ignored, others ignored
    cur_req = "R4";
    b_sel = 5'd3; b_pp = 16'd3; b_cmp = 16'd0;
    for (int i = 0; i < 8; i++) step(1'b1, '0);
    step(1'b0, 31'h0000_0004);
    for (int i = 0; i < 3; i++) step(1'b1, 31'h0000_0003);
    step(1'b0, 31'h7FFF_FFFB);
    // R10: sync coincides with tick
    cur_req = "R10";
    step(1'b1, '0);
    step(1'b1, 31'h0000_0004);
    step(1'b1, '0);
    // R4: highest selector value
    cur_req = "R4";
    b_sel = 5'd31;
    for (int i = 0; i < 4; i++) step(1'b1, '0);
    step(1'b1, 31'h4000_0000);
    step(1'b1, 31'h3FFF_FFFF);
    // R9: trigger in sync mode
    cur_req = "R9";
    b_cmp = 16'd3;
    for (int i = 0; i < 6; i++) step(1'b1, '0);

    // R5: free-run rollover in sync mode
    cur_req = "R5";
    b_sel = 5'd5; b_ps = 16'd0; b_cmp = 16'hFFFF;
    for (int i = 0; i < 65545; i++) step(1'b1, '0);

    // R1: enable dropped mid-count
    cur_req = "R1";
    b_sel = 5'd0; b_pp = 16'd9; b_ps = 16'd5;
    for (int i = 0; i < 4; i++) step(1'b1, '0);
    b_run = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b1, '0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule